// File: doc/BRIEF.md
# Sensor-Priority Intersection Light Controller

This block drives the lamps of a crossing between a main road and a side road. The main road holds green unless a vehicle waits on the side road. The side road's vehicle detector is a raw, asynchronous and bouncy contact. The block synchronises and filters it before any decision depends on it. All phase timing advances on a one-cycle `tick_i` enable, normally one pulse per second from a divider outside the block. The lamps themselves never depend on the fast clock rate.

The controller has four states. `PH_MAIN_GO` is main green with side red, and it is the reset state. `PH_MAIN_WARN` is main yellow with side red. `PH_SIDE_GO` is side green with main red. `PH_SIDE_WARN` is side yellow with main red. The transitions are:
- MAIN_GO to MAIN_WARN when a filtered request is present and the main green timer has served its switch-set minimum.
- MAIN_WARN to SIDE_GO when the yellow timer expires.
- SIDE_GO to SIDE_WARN when the side green timer reaches its switch-set limit, or earlier when the request has gone quiet.
- SIDE_WARN to MAIN_GO when the yellow timer expires.

Every state change clears all phase timers. The two green lengths are read from switch inputs at run time. The yellow length is a build-time parameter.

Top module: `xroad_light_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is main green and side red. This holds when reset is asserted in the middle of operation.
- R2: With no filtered side request, the main lamp stays green and the side lamp stays red for any number of ticks.
- R3: Lamp vectors are encoded as bit 2 = green, bit 1 = yellow, bit 0 = red. Each road changes only along green → yellow → red → green and never goes from green straight to red.
- R4: Each lamp vector has exactly one bit set in every cycle.
- R5: Main green ends only when a filtered request is present and at least `main_green_i` ticks have passed in main green. If the minimum is already served when the request arrives, main yellow follows at the next edge after the filtered request appears.
- R6: Side green lasts `side_green_i` ticks while the request stays present, then side yellow follows.
- R7: Side green ends early, before its limit, at the second tick that occurs while the filtered request is continuously low.
- R8: Each yellow phase lasts `YEL_TICKS` ticks (default 2). Main yellow is followed by side green, and side yellow is always followed by main green.
- R9: A switch value of zero for either green limit acts as one tick.
- R10: The sensor passes a two-flop synchroniser. It is accepted only after it has held a new level for `DEB_CYCLES` consecutive clocks (default 4), so a 2-clock pulse is ignored.
- R11: Without `tick_i`, no timer advances. A yellow phase is held for any number of clocks in which no tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single system clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle timing enable (human-scale tick) |
| sensor_i | input | 1 | Raw asynchronous side-road vehicle detector |
| main_green_i | input | TW | Main green minimum in ticks (0 acts as 1) |
| side_green_i | input | TW | Side green maximum in ticks (0 acts as 1) |
| main_lamp_o | output | 3 | Main road lamp, one-hot {green, yellow, red} |
| side_lamp_o | output | 3 | Side road lamp, one-hot {green, yellow, red} |

## Verification
The bench walks the exact tick count at which each phase ends. A timer that compares off by one would move a lamp one tick early or late, and the bench would catch that. It drives the sensor low during side green and expects yellow at the second quiet tick. A design that ignored the quiet rule would run to the full side limit, and one that ended on the first quiet tick would leave early. Zero switch values, a 2-clock glitch and a just-long-enough pulse probe the filter and the zero guard. A design that skipped either would hang in a zero-length phase or yield main green to noise. A long tick-free stretch in yellow and a reset during side green cover a timer that counts clocks instead of ticks and a reset that misses a state. A monitor watches every cycle for lamp vectors that are not one-hot or that step out of order.

// File: rtl/xroad_pkg.sv
package xroad_pkg;

    typedef enum logic [1:0] {
        PH_MAIN_GO   = 2'd0,
        PH_MAIN_WARN = 2'd1,
        PH_SIDE_GO   = 2'd2,
        PH_SIDE_WARN = 2'd3
    } phase_e;

    localparam logic [2:0] LAMP_GRN = 3'b100;
    localparam logic [2:0] LAMP_YEL = 3'b010;
    localparam logic [2:0] LAMP_RED = 3'b001;

endpackage

// File: rtl/xr_sensor_filter.sv
module xr_sensor_filter #(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic req_o
);
    localparam int CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          clean_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b00;
        end else begin
            sync_q <= {sync_q[0], raw_i};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= '0;
            clean_q <= 1'b0;
        end else if (sync_q[1] == clean_q) begin
            run_q   <= '0;
        end else if (run_q == CW'(DEB_CYCLES - 1)) begin
            run_q   <= '0;
            clean_q <= sync_q[1];
        end else begin
            run_q   <= run_q + 1'b1;
        end
    end

    assign req_o = clean_q;

    // R10: the filtered level only ever moves to the synchronised level
    a_r10_follows_sync: assert property (@(posedge clk) disable iff (rst)
        !$stable(clean_q) |-> (clean_q == $past(sync_q[1])));

endmodule

// File: rtl/xr_phase_timer.sv
module xr_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          en_i,
    input  logic          clr_i,
    input  logic [TW-1:0] limit_i,
    output logic          done_o
);
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] lim_eff;

    assign lim_eff = (limit_i == '0) ? TW'(1) : limit_i;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (en_i && tick_i && (cnt_q < lim_eff)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q >= lim_eff);

    // R11: the count moves only on a tick or a clear
    a_r11_tick_gate: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/xr_light_fsm.sv
module xr_light_fsm
    import xroad_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic       main_done_i,
    input  logic       side_done_i,
    input  logic       yel_done_i,
    input  logic       quiet_done_i,
    output phase_e     state_o,
    output logic       chg_o,
    output logic [2:0] main_lamp_o,
    output logic [2:0] side_lamp_o
);
    phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_MAIN_GO:   if (req_i && main_done_i)        state_d = PH_MAIN_WARN;
            PH_MAIN_WARN: if (yel_done_i)                  state_d = PH_SIDE_GO;
            PH_SIDE_GO:   if (side_done_i || quiet_done_i) state_d = PH_SIDE_WARN;
            PH_SIDE_WARN: if (yel_done_i)                  state_d = PH_MAIN_GO;
            default:                                       state_d = PH_MAIN_GO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_MAIN_GO;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        main_lamp_o = LAMP_RED;
        side_lamp_o = LAMP_RED;
        unique case (state_q)
            PH_MAIN_GO:   main_lamp_o = LAMP_GRN;
            PH_MAIN_WARN: main_lamp_o = LAMP_YEL;
            PH_SIDE_GO:   side_lamp_o = LAMP_GRN;
            PH_SIDE_WARN: side_lamp_o = LAMP_YEL;
            default:      main_lamp_o = LAMP_RED;
        endcase
    end

    assign state_o = state_q;
    assign chg_o   = (state_d != state_q) && !rst;

    a_r1_reset_main_green: assert property (@(posedge clk)
        rst |=> (main_lamp_o == LAMP_GRN && side_lamp_o == LAMP_RED));

    a_r4_one_hot: assert property (@(posedge clk) disable iff (rst)
        $onehot(main_lamp_o) && $onehot(side_lamp_o));

    a_r3_main_no_skip: assert property (@(posedge clk) disable iff (rst)
        (main_lamp_o == LAMP_GRN) |=> (main_lamp_o != LAMP_RED));

    a_r3_side_no_skip: assert property (@(posedge clk) disable iff (rst)
        (side_lamp_o == LAMP_GRN) |=> (side_lamp_o != LAMP_RED));

    // R2 and R5: main green is kept unless request and served minimum coincide
    a_r5_main_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_MAIN_GO && !(req_i && main_done_i)) |=> (state_q == PH_MAIN_GO));

    a_r8_side_warn_to_main: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_SIDE_WARN && yel_done_i) |=> (state_q == PH_MAIN_GO));

endmodule

// File: rtl/xroad_light_ctrl.sv
module xroad_light_ctrl
    import xroad_pkg::*;
#(
    parameter int TW         = 4,
    parameter int YEL_TICKS  = 2,
    parameter int DEB_CYCLES = 4,
    parameter int QUIET_TICKS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          sensor_i,
    input  logic [TW-1:0] main_green_i,
    input  logic [TW-1:0] side_green_i,
    output logic [2:0]    main_lamp_o,
    output logic [2:0]    side_lamp_o
);
    localparam logic [TW-1:0] YEL_LIM   = TW'(YEL_TICKS);
    localparam logic [TW-1:0] QUIET_LIM = TW'(QUIET_TICKS);

    phase_e state;
    logic   req, chg;
    logic   main_done, side_done, yel_done, quiet_done;
    logic   in_main_go, in_side_go, in_warn;

    assign in_main_go = (state == PH_MAIN_GO);
    assign in_side_go = (state == PH_SIDE_GO);
    assign in_warn    = (state == PH_MAIN_WARN) || (state == PH_SIDE_WARN);

    xr_sensor_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filter (
        .clk   (clk),
        .rst   (rst),
        .raw_i (sensor_i),
        .req_o (req)
    );

    xr_phase_timer #(.TW(TW)) u_main_tmr (
        .clk(clk), .rst(rst), .tick_i(tick_i), .en_i(in_main_go),
        .clr_i(chg), .limit_i(main_green_i), .done_o(main_done)
    );

    xr_phase_timer #(.TW(TW)) u_side_tmr (
        .clk(clk), .rst(rst), .tick_i(tick_i), .en_i(in_side_go),
        .clr_i(chg), .limit_i(side_green_i), .done_o(side_done)
    );

    xr_phase_timer #(.TW(TW)) u_yel_tmr (
        .clk(clk), .rst(rst), .tick_i(tick_i), .en_i(in_warn),
        .clr_i(chg), .limit_i(YEL_LIM), .done_o(yel_done)
    );

    // quiet timer restarts whenever the request is seen again
    xr_phase_timer #(.TW(TW)) u_quiet_tmr (
        .clk(clk), .rst(rst), .tick_i(tick_i), .en_i(in_side_go),
        .clr_i(chg || req), .limit_i(QUIET_LIM), .done_o(quiet_done)
    );

    xr_light_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_i        (req),
        .main_done_i  (main_done),
        .side_done_i  (side_done),
        .yel_done_i   (yel_done),
        .quiet_done_i (quiet_done),
        .state_o      (state),
        .chg_o        (chg),
        .main_lamp_o  (main_lamp_o),
        .side_lamp_o  (side_lamp_o)
    );

endmodule

// File: tb/sim_xroad_light_ctrl.sv
module sim_xroad_light_ctrl;
    localparam int TW = 4;
    localparam logic [2:0] G = 3'b100, Y = 3'b010, R = 3'b001;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_i = 1'b0;
    logic          sensor_i = 1'b0;
    logic [TW-1:0] main_green_i = 4'd2;
    logic [TW-1:0] side_green_i = 4'd3;
    logic [2:0]    main_lamp_o, side_lamp_o;

    int checks = 0;
    int errors = 0;
    int order_bad = 0;
    int hot_bad = 0;
    logic [2:0] prev_m = G, prev_s = R;

    always #2.5 clk = ~clk;

    xroad_light_ctrl #(.TW(TW)) u0 (
        .clk(clk), .rst(rst), .tick_i(tick_i), .sensor_i(sensor_i),
        .main_green_i(main_green_i), .side_green_i(side_green_i),
        .main_lamp_o(main_lamp_o), .side_lamp_o(side_lamp_o)
    );

    // {sensor, ticks[3:0], main lamp, side lamp}; walk with main=2, side=3, yellow=2
    localparam int NV = 14;
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 4'd5, G, R},   // R2 no request
        {1'b1, 4'd0, G, R},   // placeholder replaced: see R5 note below
        {1'b1, 4'd1, Y, R},   // R8 yellow 1 of 2
        {1'b1, 4'd1, R, G},   // R8 main yellow -> side green
        {1'b1, 4'd2, R, G},   // R6 side green 2 of 3
        {1'b1, 4'd1, R, Y},   // R6 side limit reached
        {1'b1, 4'd2, G, R},   // R8 side yellow -> main green
        {1'b1, 4'd1, G, R},   // R5 minimum not yet served
        {1'b1, 4'd1, Y, R},   // R5 minimum served with request
        {1'b1, 4'd2, R, G},   // R8
        {1'b0, 4'd1, R, G},   // R7 first quiet tick
        {1'b0, 4'd1, R, Y},   // R7 second quiet tick ends side green early
        {1'b0, 4'd2, G, R},   // R8
        {1'b0, 4'd4, G, R}    // R2
    };

    task automatic chk(input string req, input logic [2:0] gm, input logic [2:0] gs,
                       input logic [2:0] em, input logic [2:0] es);
        checks++;
        if (gm !== em || gs !== es) begin
            errors++;
            $display("FAIL %s: main=%b side=%b expected main=%b side=%b", req, gm, gs, em, es);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(negedge clk);
            tick_i = 1'b0;
            clocks(4);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clocks(3);
        rst = 1'b0;
        clocks(2);
    endtask

    // every-cycle monitor for R3 and R4
    always @(negedge clk) begin
        if (rst) begin
            prev_m <= main_lamp_o;
            prev_s <= side_lamp_o;
        end else begin
            if ($countones(main_lamp_o) != 1 || $countones(side_lamp_o) != 1) hot_bad++;
            if (main_lamp_o != prev_m &&
                !((prev_m == G && main_lamp_o == Y) || (prev_m == Y && main_lamp_o == R) ||
                  (prev_m == R && main_lamp_o == G))) order_bad++;
            if (side_lamp_o != prev_s &&
                !((prev_s == G && side_lamp_o == Y) || (prev_s == Y && side_lamp_o == R) ||
                  (prev_s == R && side_lamp_o == G))) order_bad++;
            prev_m <= main_lamp_o;
            prev_s <= side_lamp_o;
        end
    end

    initial begin : watchdog
        #(5 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main_seq
        clocks(3);
        chk("R1 reset", main_lamp_o, side_lamp_o, G, R);
        do_reset();
        chk("R1 after reset", main_lamp_o, side_lamp_o, G, R);

        for (int v = 0; v < NV; v++) begin
            sensor_i = VEC[v][10];
            clocks(16);
            ticks(int'(VEC[v][9:6]));
            // row 1: minimum already served when request arrives -> R5 yellow
            if (v == 1) chk("R5 served minimum", main_lamp_o, side_lamp_o, Y, R);
            else        chk("R2 R5 R6 R7 R8 table", main_lamp_o, side_lamp_o, VEC[v][5:3], VEC[v][2:0]);
        end

        // R9: zero limits act as one tick
        main_green_i = 4'd0;
        side_green_i = 4'd0;
        sensor_i = 1'b0;
        do_reset();
        sensor_i = 1'b1;
        clocks(16);
        chk("R9 zero main before tick", main_lamp_o, side_lamp_o, G, R);
        ticks(1);
        chk("R9 zero main one tick", main_lamp_o, side_lamp_o, Y, R);
        clocks(40);
        chk("R11 no tick holds yellow", main_lamp_o, side_lamp_o, Y, R);
        ticks(2);
        chk("R8 yellow after two ticks", main_lamp_o, side_lamp_o, R, G);
        ticks(1);
        chk("R9 zero side one tick", main_lamp_o, side_lamp_o, R, Y);
        ticks(2);
        chk("R8 back to main", main_lamp_o, side_lamp_o, G, R);

        // R10: glitch rejection and accepted pulse
        main_green_i = 4'd2;
        side_green_i = 4'd3;
        sensor_i = 1'b0;
        do_reset();
        ticks(3);
        sensor_i = 1'b1;
        clocks(2);
        sensor_i = 1'b0;
        clocks(16);
        chk("R10 short glitch ignored", main_lamp_o, side_lamp_o, G, R);
        sensor_i = 1'b1;
        clocks(6);
        sensor_i = 1'b0;
        clocks(16);
        chk("R10 held pulse accepted", main_lamp_o, side_lamp_o, Y, R);

        // R1: reset in the middle of side green
        sensor_i = 1'b1;
        ticks(2);
        chk("R8 side green reached", main_lamp_o, side_lamp_o, R, G);
        rst = 1'b1;
        clocks(2);
        chk("R1 mid-run reset", main_lamp_o, side_lamp_o, G, R);
        rst = 1'b0;
        sensor_i = 1'b0;
        clocks(4);

        checks++;
        if (hot_bad != 0) begin
            errors++;
            $display("FAIL R4 one-hot: violations=%0d expected 0", hot_bad);
        end
        checks++;
        if (order_bad != 0) begin
            errors++;
            $display("FAIL R3 order: violations=%0d expected 0", order_bad);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule